// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block steps an external sample-and-convert ADC front end through a programmed list of conversions. Sixteen 4-bit slots name the input channel for each conversion in turn. Each 12-bit result lands in one of sixteen 16-bit result registers. The result is placed in the upper bits, so the low nibble is always zero. A simple host register port is used to program the configuration and the channel slots, to start a run, to poll and clear an end-of-sequence flag, and to read the results. The converter itself is outside the block. The controller drives a channel code, an acquisition strobe and a one-cycle start pulse. It then waits for a done pulse carrying the sample.

A sequence is a fixed number of conversions, set by a count field holding N, which gives N+1 conversions per sequence. Each time a sequence ends, the status flag is raised. The configuration selects three further behaviours:
- Continuous mode starts the next sequence on its own after each end-of-sequence event.
- Override mode lets the shared slot/result pointer keep advancing through the whole bank, wrapping from 15 to 0. With override off, the pointer returns to 0 at every end of sequence.
- Simultaneous-sampling mode stretches the acquisition window by one clock.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After a synchronous reset, the sequencer is idle. The strobe and start outputs are low, the status flag is 0, and all sixteen result registers, the configuration and the slots read 0.
- R2: A host write to address 0x00 with bit 13 set starts a run when the sequencer is idle. A second such write while a run is busy is ignored: the run still makes exactly N+1 conversions and then stops.
- R3: Before each conversion, the acquisition strobe stays high for exactly 1 + ACQ + SIM consecutive clocks. It is then followed at once by a one-clock start pulse. ACQ is control bits [7:4] and SIM is control bit 2.
- R4: Each done pulse stores its 12-bit sample, shifted left by four bits with the low four bits zero, into the result register at the current pointer. Result k is read at address 0x20+k.
- R5: Control bits [11:8] hold N. Each sequence makes N+1 conversions, and its last done pulse sets the status flag. The flag is read at status address 0x01, bit 0, and busy is bit 1.
- R6: With override off (control bit 1 = 0), the pointer returns to 0 at every end of sequence. With continuous mode off (control bit 0 = 0), the sequencer then goes idle.
- R7: With continuous mode on, a new sequence begins after each end of sequence without another start write. Clearing control bit 0 stops the run at the next end of sequence.
- R8: With override on, the pointer keeps advancing at the end of a sequence and wraps from 15 to 0. The pointer is also kept across idle periods. With N=7, the first sequence fills results 0 to 7, the next fills 8 to 15, and the one after that fills 0 to 7 again.
- R9: Writing a 1 to status bit 0 clears the flag. If a clear write and an end of sequence fall in the same cycle, the flag ends up set.
- R10: During each conversion, the channel output carries the 4-bit code of the slot at the current pointer. Slot k is written and read at address 0x10+k, using data bits [3:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 6 | Host register address (write and read) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr (combinational) |
| seq_irq | output | 1 | End-of-sequence status flag |
| cv_chan | output | 4 | Channel code to the converter |
| cv_acq | output | 1 | Acquisition window strobe |
| cv_start | output | 1 | One-cycle conversion start |
| cv_done | input | 1 | Conversion finished, sample valid |
| cv_data | input | 12 | Converted sample |

## Verification
The assertions take three things for granted about the inputs:
- The converter returns at most one done pulse per start pulse, and never before the start pulse has ended.
- The host does not change the conversion count, the acquisition length or the sampling mode while a run is busy.
- The host may clear only the continuous-run bit, and only in a write that repeats the other fields.

The stimulus holds to these rules. The converter model in the bench answers each start with a single done pulse after 1 to 4 clocks. Every write made during a run repeats the configuration already in force. Random configurations are applied only while the sequencer is idle.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
    localparam int NUM_SLOTS = 16;
    localparam int CHAN_W    = 4;
    localparam int SMP_W     = 12;
    localparam int RES_W     = 16;
    localparam int ACQ_W     = 4;
    localparam int HOST_AW   = 6;
    localparam int HOST_DW   = 16;
    localparam int PTR_W     = $clog2(NUM_SLOTS);

    // control word field positions (start bit position is fixed by behaviour)
    localparam int CTL_CONT_BIT  = 0;
    localparam int CTL_OVR_BIT   = 1;
    localparam int CTL_SIM_BIT   = 2;
    localparam int CTL_ACQ_LSB   = 4;
    localparam int CTL_MAX_LSB   = 8;
    localparam int CTL_START_BIT = 13;
    localparam int ST_FLAG_BIT   = 0;
    localparam int ST_BUSY_BIT   = 1;

    // address map: page = upper address bits, index = lower PTR_W bits
    localparam int CTL_IDX   = 0;
    localparam int STAT_IDX  = 1;
    localparam int REG_PAGE  = 0;
    localparam int SLOT_PAGE = 1;
    localparam int RES_PAGE  = 2;

    typedef struct packed {
        logic [PTR_W-1:0] max_conv;
        logic [ACQ_W-1:0] acq_ps;
        logic             simul;
        logic             ovr;
        logic             cont;
    } seq_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACQ    = 2'd1,
        ST_CSTART = 2'd2,
        ST_WAIT   = 2'd3
    } seq_st_e;
endpackage

// File: rtl/adc_seq_regs.sv
`timescale 1ns/1ps
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int NSLOT = NUM_SLOTS,
    parameter int CW    = CHAN_W,
    parameter int AW    = HOST_AW,
    parameter int DW    = HOST_DW
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      host_wr,
    input  logic [AW-1:0]             host_addr,
    input  logic [DW-1:0]             host_wdata,
    input  logic                      seq_eos,
    output seq_cfg_t                  cfg_o,
    output logic                      start_o,
    output logic [NSLOT-1:0][CW-1:0]  slot_o,
    output logic                      flag_o
);
    localparam int PW = $clog2(NSLOT);

    typedef struct packed {
        seq_cfg_t                 cfg;
        logic [NSLOT-1:0][CW-1:0] slot;
        logic                     flag;
    } regs_t;

    regs_t r_d, r_q;

    logic ctl_wr, stat_wr, slot_wr, clr;
    logic unused_bits;

    assign ctl_wr  = host_wr && (host_addr == AW'(CTL_IDX));
    assign stat_wr = host_wr && (host_addr == AW'(STAT_IDX));
    assign slot_wr = host_wr && (host_addr[AW-1:PW] == (AW-PW)'(SLOT_PAGE));
    assign clr     = stat_wr && host_wdata[ST_FLAG_BIT];
    assign unused_bits = ^{host_wdata[DW-1:CTL_START_BIT+1],
                           host_wdata[CTL_START_BIT-1:CTL_MAX_LSB+PTR_W],
                           host_wdata[CTL_ACQ_LSB-1:CTL_SIM_BIT+1]};

    always_comb begin
        r_d = r_q;
        if (ctl_wr) begin
            r_d.cfg.cont     = host_wdata[CTL_CONT_BIT];
            r_d.cfg.ovr      = host_wdata[CTL_OVR_BIT];
            r_d.cfg.simul    = host_wdata[CTL_SIM_BIT];
            r_d.cfg.acq_ps   = host_wdata[CTL_ACQ_LSB +: ACQ_W];
            r_d.cfg.max_conv = host_wdata[CTL_MAX_LSB +: PTR_W];
        end
        if (slot_wr) begin
            r_d.slot[host_addr[PW-1:0]] = host_wdata[CW-1:0];
        end
        if (clr) begin
            r_d.flag = 1'b0;
        end
        if (seq_eos) begin
            r_d.flag = 1'b1;   // set has priority over clear
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_o   = r_q.cfg;
    assign slot_o  = r_q.slot;
    assign flag_o  = r_q.flag;
    assign start_o = ctl_wr && host_wdata[CTL_START_BIT];

    // R9: end of sequence leaves the flag set, even against a clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        seq_eos |=> flag_o);
    // R9: a clear without a coincident set drops the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !seq_eos) |=> !flag_o);
endmodule

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NSLOT = NUM_SLOTS,
    parameter int AQW   = ACQ_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  seq_cfg_t                  cfg,
    input  logic                      start,
    input  logic                      cv_done,
    output logic                      cv_acq,
    output logic                      cv_start,
    output logic                      wr_en,
    output logic [$clog2(NSLOT)-1:0]  ptr_o,
    output logic                      eos,
    output logic                      busy
);
    localparam int PW = $clog2(NSLOT);
    localparam int TW = AQW + 1;

    typedef struct packed {
        seq_st_e       st;
        logic [TW-1:0] tcnt;
        logic [PW-1:0] ccnt;
        logic [PW-1:0] ptr;
    } fsm_t;

    fsm_t f_d, f_q;

    logic [TW-1:0] acq_last;
    logic          last_conv;
    logic [PW-1:0] ptr_inc;

    assign acq_last  = TW'(cfg.acq_ps) + TW'(cfg.simul);
    assign last_conv = (f_q.ccnt >= cfg.max_conv);
    assign ptr_inc   = (f_q.ptr == PW'(NSLOT-1)) ? '0 : f_q.ptr + 1'b1;

    always_comb begin
        f_d   = f_q;
        wr_en = 1'b0;
        eos   = 1'b0;
        unique case (f_q.st)
            ST_IDLE: begin
                if (start) begin
                    f_d.st   = ST_ACQ;
                    f_d.tcnt = '0;
                    f_d.ccnt = '0;
                end
            end
            ST_ACQ: begin
                if (f_q.tcnt == acq_last) begin
                    f_d.st   = ST_CSTART;
                    f_d.tcnt = '0;
                end else begin
                    f_d.tcnt = f_q.tcnt + 1'b1;
                end
            end
            ST_CSTART: begin
                f_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (cv_done) begin
                    wr_en = 1'b1;
                    if (last_conv) begin
                        eos      = 1'b1;
                        f_d.ccnt = '0;
                        f_d.ptr  = cfg.ovr ? ptr_inc : '0;
                        f_d.st   = cfg.cont ? ST_ACQ : ST_IDLE;
                    end else begin
                        f_d.ccnt = f_q.ccnt + 1'b1;
                        f_d.ptr  = ptr_inc;
                        f_d.st   = ST_ACQ;
                    end
                end
            end
            default: f_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '{st: ST_IDLE, tcnt: '0, ccnt: '0, ptr: '0};
        end else begin
            f_q <= f_d;
        end
    end

    assign cv_acq   = (f_q.st == ST_ACQ);
    assign cv_start = (f_q.st == ST_CSTART);
    assign busy     = (f_q.st != ST_IDLE);
    assign ptr_o    = f_q.ptr;

    // R3: start pulse only directly after the acquisition window
    a_r3_start_after_acq: assert property (@(posedge clk) disable iff (rst)
        cv_start |-> $past(cv_acq));
    // R6: pointer restarts at zero without override
    a_r6_ptr_restart: assert property (@(posedge clk) disable iff (rst)
        (eos && !cfg.ovr) |=> (ptr_o == '0));
    // R6: single run goes idle at end of sequence
    a_r6_single_idle: assert property (@(posedge clk) disable iff (rst)
        (eos && !cfg.cont) |=> !busy);
    // R7: continuous run re-enters acquisition by itself
    a_r7_cont_restart: assert property (@(posedge clk) disable iff (rst)
        (eos && cfg.cont) |=> cv_acq);
    // R8: override wraps the pointer from the top slot to zero
    a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cfg.ovr && ptr_o == PW'(NSLOT-1)) |=> (ptr_o == '0));
endmodule

// File: rtl/adc_seq_results.sv
`timescale 1ns/1ps
module adc_seq_results
    import adc_seq_pkg::*;
#(
    parameter int NSLOT = NUM_SLOTS,
    parameter int SW    = SMP_W,
    parameter int RW    = RES_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [$clog2(NSLOT)-1:0]  wr_idx,
    input  logic [SW-1:0]             smp,
    output logic [NSLOT-1:0][RW-1:0]  res_o
);
    localparam int PAD = RW - SW;

    logic [NSLOT-1:0][RW-1:0] res_d, res_q;
    logic [RW-1:0]            aligned;

    assign aligned = {smp, {PAD{1'b0}}};

    for (genvar i = 0; i < NSLOT; i++) begin : g_res
        always_comb begin
            res_d[i] = res_q[i];
            if (wr_en && (wr_idx == i[$clog2(NSLOT)-1:0])) begin
                res_d[i] = aligned;
            end
        end

        // R4: stored results never carry bits below the sample field
        a_r4_left_just: assert property (@(posedge clk) disable iff (rst)
            (res_q[i][PAD-1:0] == '0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_o = res_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NSLOT = NUM_SLOTS,
    parameter int CW    = CHAN_W,
    parameter int SW    = SMP_W,
    parameter int RW    = RES_W,
    parameter int AW    = HOST_AW,
    parameter int DW    = HOST_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          seq_irq,
    output logic [CW-1:0] cv_chan,
    output logic          cv_acq,
    output logic          cv_start,
    input  logic          cv_done,
    input  logic [SW-1:0] cv_data
);
    localparam int PW = $clog2(NSLOT);

    seq_cfg_t                 cfg;
    logic                     start, flag, wr_en, eos, busy;
    logic [PW-1:0]            ptr;
    logic [NSLOT-1:0][CW-1:0] slots;
    logic [NSLOT-1:0][RW-1:0] res;
    logic [AW-PW-1:0]         page;
    logic [PW-1:0]            idx;

    adc_seq_regs #(.NSLOT(NSLOT), .CW(CW), .AW(AW), .DW(DW)) regs_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .seq_eos(eos), .cfg_o(cfg), .start_o(start),
        .slot_o(slots), .flag_o(flag)
    );

    adc_seq_fsm #(.NSLOT(NSLOT), .AQW(ACQ_W)) fsm_i (
        .clk(clk), .rst(rst), .cfg(cfg), .start(start), .cv_done(cv_done),
        .cv_acq(cv_acq), .cv_start(cv_start), .wr_en(wr_en), .ptr_o(ptr),
        .eos(eos), .busy(busy)
    );

    adc_seq_results #(.NSLOT(NSLOT), .SW(SW), .RW(RW)) res_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(ptr), .smp(cv_data),
        .res_o(res)
    );

    assign cv_chan = slots[ptr];
    assign seq_irq = flag;
    assign page    = host_addr[AW-1:PW];
    assign idx     = host_addr[PW-1:0];

    always_comb begin
        host_rdata = '0;
        if (page == (AW-PW)'(REG_PAGE)) begin
            if (idx == PW'(CTL_IDX)) begin
                host_rdata[CTL_CONT_BIT]              = cfg.cont;
                host_rdata[CTL_OVR_BIT]               = cfg.ovr;
                host_rdata[CTL_SIM_BIT]               = cfg.simul;
                host_rdata[CTL_ACQ_LSB +: ACQ_W]      = cfg.acq_ps;
                host_rdata[CTL_MAX_LSB +: PTR_W]      = cfg.max_conv;
            end else if (idx == PW'(STAT_IDX)) begin
                host_rdata[ST_FLAG_BIT] = flag;
                host_rdata[ST_BUSY_BIT] = busy;
            end
        end else if (page == (AW-PW)'(SLOT_PAGE)) begin
            host_rdata[CW-1:0] = slots[idx];
        end else if (page == (AW-PW)'(RES_PAGE)) begin
            host_rdata[RW-1:0] = res[idx];
        end
    end

    // R1/R5: the flag output only rises on the cycle after a completed sequence
    a_r5_flag_source: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_irq) |-> $past(cv_done));
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst;
    logic        wr_m, clash_now;
    logic [5:0]  addr_m;
    logic [15:0] wdata_m;
    logic        host_wr;
    logic [5:0]  host_addr;
    logic [15:0] host_wdata, host_rdata;
    logic        seq_irq, cv_acq, cv_start, cv_done;
    logic [3:0]  cv_chan;
    logic [11:0] cv_data;

    assign host_wr    = wr_m | clash_now;
    assign host_addr  = clash_now ? 6'h01 : addr_m;
    assign host_wdata = clash_now ? 16'h0001 : wdata_m;

    adc_seq_ctrl dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .seq_irq(seq_irq),
        .cv_chan(cv_chan), .cv_acq(cv_acq), .cv_start(cv_start),
        .cv_done(cv_done), .cv_data(cv_data)
    );

    int total = 0, bad = 0;
    int eos_seen = 0, conv_seen = 0;
    int exp_ptr = 0, exp_cnt = 0;
    int m_max = 0, m_acq = 0, m_sim = 0, m_ovr = 0;
    logic [15:0] exp_res [16];
    logic [3:0]  m_slot [16];
    bit clash_arm = 0;
    bit finished = 0;

    task automatic chk(string req, string what, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] ctl(int mx, int acq, int sim, int ovr, int cont, int st);
        return 16'((st << 13) | (mx << 8) | (acq << 4) | (sim << 2) | (ovr << 1) | cont);
    endfunction

    function automatic logic [15:0] aligned(logic [11:0] s);
        return {s, 4'h0};
    endfunction

    task automatic host_write(logic [5:0] a, logic [15:0] d);
        @(negedge clk);
        wr_m = 1'b1; addr_m = a; wdata_m = d;
        @(negedge clk);
        wr_m = 1'b0;
    endtask

    task automatic host_read(logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        addr_m = a;
        #1 d = host_rdata;
    endtask

    task automatic set_ctl(int mx, int acq, int sim, int ovr, int cont, int st);
        m_max = mx; m_acq = acq; m_sim = sim; m_ovr = ovr;
        host_write(6'h00, ctl(mx, acq, sim, ovr, cont, st));
    endtask

    task automatic wait_idle(string req);
        logic [15:0] s;
        int n = 0;
        s = 16'h0002;
        while (s[1] && n < 5000) begin
            host_read(6'h01, s);
            n++;
        end
        chk(req, "run finished", int'(s[1]), 0);
    endtask

    task automatic compare_all(string req);
        logic [15:0] v;
        for (int i = 0; i < 16; i++) begin
            host_read(6'(32 + i), v);
            chk(req, $sformatf("result[%0d]", i), int'(v), int'(exp_res[i]));
        end
    endtask

    // converter model and strobe monitor
    initial begin
        int acq_run = 0, lat = 0;
        bit pend = 0;
        logic [11:0] nd;
        cv_done = 1'b0; cv_data = '0; clash_now = 1'b0;
        forever begin
            @(negedge clk);
            if (cv_done) begin
                cv_done = 1'b0;
                clash_now = 1'b0;
            end
            if (rst) begin
                acq_run = 0; pend = 0;
            end else begin
                if (cv_acq) acq_run++;
                if (cv_start) begin
                    chk("R3", "acquisition length", acq_run, 1 + m_acq + m_sim);
                    chk("R10", "channel code", int'(cv_chan), int'(m_slot[exp_ptr]));
                    acq_run = 0;
                    pend = 1;
                    lat = $urandom_range(0, 3);
                end else if (pend) begin
                    if (lat == 0) begin
                        nd = 12'($urandom);
                        cv_data = nd;
                        cv_done = 1'b1;
                        pend = 0;
                        exp_res[exp_ptr] = aligned(nd);
                        conv_seen++;
                        if (exp_cnt == m_max) begin
                            eos_seen++;
                            exp_cnt = 0;
                            exp_ptr = m_ovr ? (exp_ptr + 1) % 16 : 0;
                            if (clash_arm) begin
                                clash_now = 1'b1;
                                clash_arm = 0;
                            end
                        end else begin
                            exp_cnt++;
                            exp_ptr = (exp_ptr + 1) % 16;
                        end
                    end else begin
                        lat--;
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int e0, c0;
        void'($urandom(32'h5EED_ADC1));
        rst = 1'b1; wr_m = 1'b0; addr_m = '0; wdata_m = '0;
        for (int i = 0; i < 16; i++) begin
            exp_res[i] = '0;
            m_slot[i]  = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        host_read(6'h01, v);
        chk("R1", "status after reset", int'(v), 0);
        host_read(6'h00, v);
        chk("R1", "control after reset", int'(v), 0);
        chk("R1", "strobe low", int'(cv_acq), 0);
        chk("R1", "start low", int'(cv_start), 0);
        compare_all("R1");

        // program slots with random channel codes
        for (int i = 0; i < 16; i++) begin
            m_slot[i] = 4'($urandom);
            host_write(6'(16 + i), {12'h0, m_slot[i]});
        end
        host_read(6'h15, v);
        chk("R10", "slot readback", int'(v), int'(m_slot[5]));

        // R5/R4/R6: single sequence of four conversions
        set_ctl(3, 2, 0, 0, 0, 1);
        wait_idle("R6");
        chk("R5", "sequences", eos_seen, 1);
        chk("R5", "conversions", conv_seen, 4);
        host_read(6'h01, v);
        chk("R5", "flag after sequence", int'(v[0]), 1);
        compare_all("R4");

        // R9: clear
        host_write(6'h01, 16'h0001);
        host_read(6'h01, v);
        chk("R9", "flag after clear", int'(v[0]), 0);

        // R2: second start while busy is ignored; R6 pointer restarts at 0
        e0 = eos_seen; c0 = conv_seen;
        set_ctl(2, 5, 1, 0, 0, 1);
        repeat (3) @(negedge clk);
        host_write(6'h00, ctl(2, 5, 1, 0, 0, 1));
        wait_idle("R2");
        chk("R2", "sequences from double start", eos_seen - e0, 1);
        chk("R2", "conversions from double start", conv_seen - c0, 3);
        compare_all("R6");

        // R7/R8: override with continuous run
        host_write(6'h01, 16'h0001);
        e0 = eos_seen;
        set_ctl(7, 0, 0, 1, 1, 1);
        while (eos_seen < e0 + 3) @(negedge clk);
        host_read(6'h01, v);
        chk("R7", "still busy without new start", int'(v[1]), 1);
        host_write(6'h00, ctl(7, 0, 0, 1, 0, 0));
        wait_idle("R7");
        chk("R7", "at least three sequences", int'(eos_seen - e0 >= 3), 1);
        compare_all("R8");

        // R9: clear coinciding with end of sequence, set wins
        host_write(6'h01, 16'h0001);
        clash_arm = 1;
        set_ctl(1, 1, 0, 0, 0, 1);
        wait_idle("R9");
        host_read(6'h01, v);
        chk("R9", "set wins over clear", int'(v[0]), 1);
        chk("R9", "seq_irq pin", int'(seq_irq), 1);
        host_write(6'h01, 16'h0001);
        host_read(6'h01, v);
        chk("R9", "flag after later clear", int'(v[0]), 0);

        // random single runs
        for (int it = 0; it < 8; it++) begin
            int mx, aq, sm, ov;
            mx = $urandom_range(0, 15);
            aq = $urandom_range(0, 7);
            sm = $urandom_range(0, 1);
            ov = $urandom_range(0, 1);
            e0 = eos_seen;
            set_ctl(mx, aq, sm, ov, 0, 1);
            wait_idle("R6");
            chk("R5", "random run sequence count", eos_seen - e0, 1);
            host_read(6'h01, v);
            chk("R5", "random run flag", int'(v[0]), 1);
            compare_all(ov ? "R8" : "R4");
            host_write(6'h01, 16'h0001);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule